// File: doc/BRIEF.md
# Two-Way Dataflow Select Node with Deferred Discard

This block is a two-input selection node for a latency-insensitive dataflow network. Three token streams enter it: a stream of select bits and two data streams, A and B. One output data stream leaves it. Each stream has a valid/ready handshake. Tokens are matched by index. The n-th select token picks between the n-th A token and the n-th B token. The picked value becomes the n-th output token, and the other value is consumed and thrown away.

The node does not wait for the losing token. As soon as the select token and the chosen data token are both present, and the output has room, the value is forwarded. The node then records a debt against the other input. A per-input debt counter drops that input's head tokens when they arrive, one per owed index. This happens independently of the output path, so a stalled consumer does not hold back discards. A stream that still owes discards cannot be selected until its debt is paid. This keeps the index alignment exact. Each debt counter has a fixed ceiling, and the node stops creating new debt when a counter reaches it.

Each of the four streams passes through a small internal FIFO. The output is therefore always taken from a register-backed store.

Top module: `dfsel_node`

## Requirements
- R1: In the cycle after a synchronous active-high reset, out_valid is 0 and sel_ready, a_ready and b_ready are all 1.
- R2: A select token of 1 routes the A token of the same index to the output, and a select token of 0 routes the B token. The output order matches the index order.
- R3: For every index, the token of the unselected input is consumed and never appears at the output. Once n tokens have been taken on each input stream and n outputs have been drained, the node is balanced, and the next index routes correctly.
- R4: Forwarding does not wait for the unselected input. A select token of 1 and one A token, with no B token present, still produce the output.
- R5: Owed discards are performed while the output FIFO is full. An input whose tokens are all owed never fills up while out_ready is held low.
- R6: While out_valid is 1 and out_ready is 0, out_valid stays 1 and out_data stays unchanged on the next cycle.
- R7: Each debt counter is capped at OWE_LIMIT (default 5). When the debt owed by one input reaches the cap, no further token is routed from the other input until a discard lowers the debt.
- R8: An input token is taken only in a cycle where its valid and ready are both 1. Ready falls to 0 when that stream's FIFO holds FIFO_DEPTH (default 4) tokens, and a valid asserted while ready is 0 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sel_valid | input | 1 | Select token offered |
| sel_bit | input | 1 | Select value: 1 picks A, 0 picks B |
| sel_ready | output | 1 | Select FIFO can accept a token |
| a_valid | input | 1 | A token offered |
| a_data | input | DATA_W | A token value |
| a_ready | output | 1 | A FIFO can accept a token |
| b_valid | input | 1 | B token offered |
| b_data | input | DATA_W | B token value |
| b_ready | output | 1 | B FIFO can accept a token |
| out_valid | output | 1 | Output token available |
| out_data | output | DATA_W | Output token value |
| out_ready | input | 1 | Consumer takes the output token |

## Verification
The checker watches four things on every cycle:
- the reset clearing of the output;
- that the output is held steady under back-pressure;
- that no input is ever routed while it still owes discards, and that both inputs are never routed at once;
- that each debt counter stays at or below its cap and moves by at most one per clock.

Some behaviours show only in the bench's token scenarios. These are the index-exact pairing of outputs with select values under random gaps and back-pressure, the return to a balanced state after a drain, and discards completing while the consumer is stalled. The stall at the debt ceiling and the refusal of pushes into a full FIFO are also shown this way.

// File: rtl/dfsel_pkg.sv
`timescale 1ns/1ps
package dfsel_pkg;

  // One clock's worth of decisions made by the routing control.
  typedef struct packed {
    logic route_a;  // forward head of A to the output FIFO
    logic route_b;  // forward head of B to the output FIFO
    logic drop_a;   // discard head of A against its debt
    logic drop_b;   // discard head of B against its debt
  } step_t;

  // Bits needed to hold a count from 0 up to and including lim.
  function automatic int cnt_bits(input int lim);
    return (lim < 1) ? 1 : $clog2(lim + 1);
  endfunction

endpackage

// File: rtl/dfsel_fifo.sv
`timescale 1ns/1ps
// Small synchronous FIFO, power-of-two depth, head visible without a pop.
module dfsel_fifo #(
  parameter int W     = 16,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] push_data,
  input  logic         pop,
  output logic [W-1:0] head,
  output logic         empty,
  output logic         full
);
  localparam int AW = (DEPTH < 2) ? 1 : $clog2(DEPTH);
  localparam int CW = AW + 1;

  logic [W-1:0]  store [DEPTH];
  logic [AW-1:0] wr_ptr;
  logic [AW-1:0] rd_ptr;
  logic [CW-1:0] fill;

  logic do_push;
  logic do_pop;

  assign empty   = (fill == '0);
  assign full    = (fill == CW'(DEPTH));
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign head    = store[rd_ptr];

  // Storage has no reset so it can map onto RAM.
  always_ff @(posedge clk) begin
    if (do_push) store[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      fill   <= '0;
    end else begin
      if (do_push) wr_ptr <= wr_ptr + 1'b1;
      if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
      case ({do_push, do_pop})
        2'b10:   fill <= fill + 1'b1;
        2'b01:   fill <= fill - 1'b1;
        default: fill <= fill;
      endcase
    end
  end

endmodule

// File: rtl/dfsel_debt.sv
`timescale 1ns/1ps
// Counts discards still owed by one input.
module dfsel_debt #(
  parameter int LIMIT = 5,
  parameter int CW    = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          incr,
  input  logic          decr,
  output logic [CW-1:0] count,
  output logic          clear,
  output logic          at_cap
);
  assign clear  = (count == '0);
  assign at_cap = (count == CW'(LIMIT));

  always_ff @(posedge clk) begin
    if (rst) begin
      count <= '0;
    end else begin
      // Simultaneous increment and decrement cancel out.
      case ({incr, decr})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

endmodule

// File: rtl/dfsel_ctrl.sv
`timescale 1ns/1ps
// Routing and discard decisions. Lane 0 is A (select 1), lane 1 is B (select 0).
module dfsel_ctrl
  import dfsel_pkg::*;
(
  input  logic       sel_empty,
  input  logic       sel_head,
  input  logic       out_full,
  input  logic [1:0] lane_empty,
  input  logic [1:0] debt_clear,
  input  logic [1:0] debt_cap,
  output step_t      step
);
  logic can_emit;

  assign can_emit = !out_full && !sel_empty;

  always_comb begin
    step = '0;
    // Discards depend only on debt and presence, never on the output side.
    step.drop_a = !debt_clear[0] && !lane_empty[0];
    step.drop_b = !debt_clear[1] && !lane_empty[1];
    // A lane with outstanding debt holds older tokens at its head, so it
    // must not be routed; routing also creates debt on the other lane.
    step.route_a = can_emit && sel_head && !lane_empty[0] &&
                   debt_clear[0] && !debt_cap[1];
    step.route_b = can_emit && !sel_head && !lane_empty[1] &&
                   debt_clear[1] && !debt_cap[0];
  end

endmodule

// File: rtl/dfsel_node.sv
`timescale 1ns/1ps
module dfsel_node
  import dfsel_pkg::*;
#(
  parameter int DATA_W     = 16,
  parameter int FIFO_DEPTH = 4,
  parameter int OUT_DEPTH  = 4,
  parameter int OWE_LIMIT  = FIFO_DEPTH + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sel_valid,
  input  logic              sel_bit,
  output logic              sel_ready,
  input  logic              a_valid,
  input  logic [DATA_W-1:0] a_data,
  output logic              a_ready,
  input  logic              b_valid,
  input  logic [DATA_W-1:0] b_data,
  output logic              b_ready,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  input  logic              out_ready
);
  localparam int OWE_W = cnt_bits(OWE_LIMIT);

  // Select FIFO
  logic sel_head, sel_empty, sel_full, sel_pop;

  dfsel_fifo #(.W(1), .DEPTH(FIFO_DEPTH)) u_sel_q (
    .clk(clk), .rst(rst),
    .push(sel_valid), .push_data(sel_bit),
    .pop(sel_pop), .head(sel_head),
    .empty(sel_empty), .full(sel_full)
  );
  assign sel_ready = !sel_full;

  // Data lanes: index 0 is A, index 1 is B.
  logic              in_valid   [2];
  logic [DATA_W-1:0] in_data    [2];
  logic [DATA_W-1:0] lane_head  [2];
  logic [1:0]        lane_empty;
  logic [1:0]        lane_full;
  logic [1:0]        lane_pop;
  logic [1:0]        debt_incr;
  logic [1:0]        debt_decr;
  logic [1:0]        debt_clear;
  logic [1:0]        debt_cap;
  logic [OWE_W-1:0]  debt_cnt   [2];

  step_t step;

  assign in_valid[0] = a_valid;
  assign in_valid[1] = b_valid;
  assign in_data[0]  = a_data;
  assign in_data[1]  = b_data;

  // Per-lane pop and debt wiring: route from this lane or drop against its
  // debt; routing from the other lane adds a debt here.
  assign lane_pop[0]  = step.route_a || step.drop_a;
  assign lane_pop[1]  = step.route_b || step.drop_b;
  assign debt_incr[0] = step.route_b;
  assign debt_incr[1] = step.route_a;
  assign debt_decr[0] = step.drop_a;
  assign debt_decr[1] = step.drop_b;

  for (genvar g = 0; g < 2; g++) begin : g_lane
    dfsel_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) u_q (
      .clk(clk), .rst(rst),
      .push(in_valid[g]), .push_data(in_data[g]),
      .pop(lane_pop[g]), .head(lane_head[g]),
      .empty(lane_empty[g]), .full(lane_full[g])
    );

    dfsel_debt #(.LIMIT(OWE_LIMIT), .CW(OWE_W)) u_debt (
      .clk(clk), .rst(rst),
      .incr(debt_incr[g]), .decr(debt_decr[g]),
      .count(debt_cnt[g]), .clear(debt_clear[g]), .at_cap(debt_cap[g])
    );
  end

  assign a_ready = !lane_full[0];
  assign b_ready = !lane_full[1];

  // Output FIFO
  logic              out_empty, out_full, out_push;
  logic [DATA_W-1:0] out_in;

  dfsel_ctrl u_ctrl (
    .sel_empty(sel_empty), .sel_head(sel_head), .out_full(out_full),
    .lane_empty(lane_empty), .debt_clear(debt_clear), .debt_cap(debt_cap),
    .step(step)
  );

  assign out_push = step.route_a || step.route_b;
  assign sel_pop  = out_push;
  assign out_in   = step.route_a ? lane_head[0] : lane_head[1];

  dfsel_fifo #(.W(DATA_W), .DEPTH(OUT_DEPTH)) u_out_q (
    .clk(clk), .rst(rst),
    .push(out_push), .push_data(out_in),
    .pop(out_ready), .head(out_data),
    .empty(out_empty), .full(out_full)
  );
  assign out_valid = !out_empty;

  // Named taps for the bound checker.
  logic             tap_route_a, tap_route_b;
  logic [OWE_W-1:0] tap_debt_a, tap_debt_b;
  assign tap_route_a = step.route_a;
  assign tap_route_b = step.route_b;
  assign tap_debt_a  = debt_cnt[0];
  assign tap_debt_b  = debt_cnt[1];

endmodule

// File: rtl/dfsel_node_chk.sv
`timescale 1ns/1ps
module dfsel_node_chk #(
  parameter int DATA_W    = 16,
  parameter int OWE_W     = 3,
  parameter int OWE_LIMIT = 5
) (
  input logic              clk,
  input logic              rst,
  input logic              out_valid,
  input logic              out_ready,
  input logic [DATA_W-1:0] out_data,
  input logic              route_a,
  input logic              route_b,
  input logic [OWE_W-1:0]  debt_a,
  input logic [OWE_W-1:0]  debt_b
);
  AST_RESET_EMPTIES: assert property (@(posedge clk)
    rst |=> !out_valid);  // R1

  AST_OUTPUT_HELD: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));  // R6

  AST_SINGLE_ROUTE: assert property (@(posedge clk) disable iff (rst)
    !(route_a && route_b));  // R2

  AST_A_ROUTED_DEBT_FREE: assert property (@(posedge clk) disable iff (rst)
    route_a |-> (debt_a == '0));  // R3

  AST_B_ROUTED_DEBT_FREE: assert property (@(posedge clk) disable iff (rst)
    route_b |-> (debt_b == '0));  // R3

  AST_DEBT_CAPPED: assert property (@(posedge clk) disable iff (rst)
    (debt_a <= OWE_W'(OWE_LIMIT)) && (debt_b <= OWE_W'(OWE_LIMIT)));  // R7

  AST_DEBT_A_STEP: assert property (@(posedge clk) disable iff (rst)
    (debt_a == $past(debt_a)) || (debt_a == $past(debt_a) + 1'b1) ||
    (debt_a + 1'b1 == $past(debt_a)));  // R3

  AST_DEBT_B_STEP: assert property (@(posedge clk) disable iff (rst)
    (debt_b == $past(debt_b)) || (debt_b == $past(debt_b) + 1'b1) ||
    (debt_b + 1'b1 == $past(debt_b)));  // R3

endmodule

bind dfsel_node dfsel_node_chk #(
  .DATA_W(DATA_W), .OWE_W(OWE_W), .OWE_LIMIT(OWE_LIMIT)
) u_chk (
  .clk(clk), .rst(rst),
  .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
  .route_a(tap_route_a), .route_b(tap_route_b),
  .debt_a(tap_debt_a), .debt_b(tap_debt_b)
);

// File: tb/tb_dfsel_node.sv
`timescale 1ns/1ps
module tb_dfsel_node;
  localparam int DW  = 16;
  localparam int MAXN = 512;

  logic          clk = 1'b0;
  logic          rst;
  logic          sel_valid, sel_bit, sel_ready;
  logic          a_valid, a_ready, b_valid, b_ready;
  logic [DW-1:0] a_data, b_data;
  logic          out_valid, out_ready;
  logic [DW-1:0] out_data;

  always #2.5 clk = ~clk;

  dfsel_node #(.DATA_W(DW), .FIFO_DEPTH(4), .OUT_DEPTH(4), .OWE_LIMIT(5)) dut (
    .clk(clk), .rst(rst),
    .sel_valid(sel_valid), .sel_bit(sel_bit), .sel_ready(sel_ready),
    .a_valid(a_valid), .a_data(a_data), .a_ready(a_ready),
    .b_valid(b_valid), .b_data(b_data), .b_ready(b_ready),
    .out_valid(out_valid), .out_data(out_data), .out_ready(out_ready)
  );

  int  tests = 0;
  int  fails = 0;
  bit  finished = 0;

  logic          sel_q [MAXN];
  logic [DW-1:0] a_q   [MAXN];
  logic [DW-1:0] b_q   [MAXN];
  logic [DW-1:0] exp_q [MAXN];

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint expv);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  // Reference: per-index choice between the two data streams.
  function automatic logic [DW-1:0] pick(input logic s, input logic [DW-1:0] av,
                                        input logic [DW-1:0] bv);
    return s ? av : bv;
  endfunction

  function automatic void build_expected(input int n);
    for (int i = 0; i < n; i++) exp_q[i] = pick(sel_q[i], a_q[i], b_q[i]);
  endfunction

  task automatic idle_inputs();
    sel_valid = 0; sel_bit = 0;
    a_valid = 0; a_data = '0;
    b_valid = 0; b_data = '0;
  endtask

  // Drive the three input streams and the output ready at negedges.
  // Every popped output is compared with exp_q in order; pops beyond
  // n_out are failures.
  task automatic run_streams(input int n_sel, input int n_a, input int n_b,
                             input int n_out, input int gap, input int rdy,
                             input int settle, input string req);
    int si = 0, ai = 0, bi = 0, oi = 0, cyc = 0, quiet = 0;
    while (si < n_sel || ai < n_a || bi < n_b || oi < n_out || quiet < settle) begin
      @(negedge clk);
      cyc++;
      if (cyc > 20000) begin
        chk(0, req, "stream run stalled, outputs seen", oi, n_out);
        break;
      end
      sel_valid = (si < n_sel) && ($urandom_range(99) >= gap);
      sel_bit   = (si < n_sel) ? sel_q[si] : 1'b0;
      a_valid   = (ai < n_a) && ($urandom_range(99) >= gap);
      a_data    = (ai < n_a) ? a_q[ai] : '0;
      b_valid   = (bi < n_b) && ($urandom_range(99) >= gap);
      b_data    = (bi < n_b) ? b_q[bi] : '0;
      out_ready = ($urandom_range(99) < rdy);
      if (sel_valid && sel_ready) si++;
      if (a_valid && a_ready) ai++;
      if (b_valid && b_ready) bi++;
      if (out_valid && out_ready) begin
        if (oi < n_out)
          chk(out_data == exp_q[oi], req, $sformatf("output %0d value", oi),
              out_data, exp_q[oi]);
        else
          chk(0, req, "unexpected output token", out_data, 0);
        oi++;
      end
      if (si >= n_sel && ai >= n_a && bi >= n_b && oi >= n_out) quiet++;
      else quiet = 0;
    end
    @(negedge clk);
    idle_inputs();
    out_ready = 0;
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      fails++;
      tests++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int seed_init;
    seed_init = $urandom(32'h1D5E_0C47);
    idle_inputs();
    out_ready = 0;
    rst = 1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1: empty after reset
    chk(out_valid == 0, "R1", "out_valid", out_valid, 0);
    chk(sel_ready == 1, "R1", "sel_ready", sel_ready, 1);
    chk(a_ready == 1, "R1", "a_ready", a_ready, 1);
    chk(b_ready == 1, "R1", "b_ready", b_ready, 1);

    // R4: forward A with no B token present
    sel_q[0] = 1; a_q[0] = 16'h1111; exp_q[0] = 16'h1111;
    run_streams(1, 1, 0, 1, 0, 100, 6, "R4");
    // R3: late B token is discarded, nothing emitted
    b_q[0] = 16'h2222;
    run_streams(0, 0, 1, 0, 0, 100, 8, "R3");
    chk(b_ready == 1, "R3", "b_ready after discard", b_ready, 1);
    chk(out_valid == 0, "R3", "out_valid after discard", out_valid, 0);

    // R7: six B selections with no A tokens, cap of five debts
    for (int i = 0; i < 6; i++) begin sel_q[i] = 0; b_q[i] = DW'(16'h3000 + i); end
    build_expected(5);
    run_streams(6, 0, 6, 5, 0, 100, 20, "R7");
    chk(out_valid == 0, "R7", "out_valid at debt cap", out_valid, 0);
    a_q[0] = 16'hA000; exp_q[0] = 16'h3005;
    run_streams(0, 1, 0, 1, 0, 100, 8, "R7");
    for (int i = 0; i < 5; i++) a_q[i] = DW'(16'hA001 + i);
    run_streams(0, 5, 0, 0, 0, 100, 10, "R3");
    chk(a_ready == 1, "R3", "a_ready after debts paid", a_ready, 1);
    sel_q[0] = 1; a_q[0] = 16'hBEEF; b_q[0] = 16'h0BAD;
    build_expected(1);
    run_streams(1, 1, 1, 1, 0, 100, 8, "R3");

    // R5/R6/R8: consumer stalled
    for (int i = 0; i < 4; i++) begin sel_q[i] = 1; a_q[i] = DW'(16'h4000 + i); end
    run_streams(4, 4, 0, 0, 0, 0, 6, "R6");
    chk(out_valid == 1, "R6", "out_valid while stalled", out_valid, 1);
    chk(out_data == 16'h4000, "R6", "out_data while stalled", out_data, 16'h4000);
    for (int i = 0; i < 4; i++) b_q[i] = DW'(16'h5000 + i);
    run_streams(0, 0, 4, 0, 0, 0, 10, "R5");
    chk(b_ready == 1, "R5", "b_ready with output full", b_ready, 1);
    chk(out_data == 16'h4000, "R6", "out_data still held", out_data, 16'h4000);
    for (int i = 0; i < 4; i++) begin sel_q[i] = 1; a_q[i] = DW'(16'h4004 + i); end
    run_streams(4, 4, 0, 0, 0, 0, 6, "R8");
    chk(sel_ready == 0, "R8", "sel_ready with full FIFO", sel_ready, 0);
    chk(a_ready == 0, "R8", "a_ready with full FIFO", a_ready, 0);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      sel_valid = 1; sel_bit = 0;
    end
    @(negedge clk);
    idle_inputs();
    for (int i = 0; i < 8; i++) exp_q[i] = DW'(16'h4000 + i);
    for (int i = 0; i < 4; i++) b_q[i] = DW'(16'h5004 + i);
    run_streams(0, 0, 4, 8, 0, 100, 12, "R8");
    chk(sel_ready == 1, "R8", "sel_ready after drain", sel_ready, 1);
    chk(out_valid == 0, "R8", "out_valid after drain", out_valid, 0);

    // R2: random select, gaps and back-pressure
    for (int i = 0; i < 400; i++) begin
      sel_q[i] = 1'($urandom_range(1));
      a_q[i]   = DW'($urandom);
      b_q[i]   = DW'($urandom);
    end
    build_expected(400);
    run_streams(400, 400, 400, 400, 35, 70, 10, "R2");
    // R3: balanced after drain
    sel_q[0] = 0; a_q[0] = 16'h0001; b_q[0] = 16'h0002;
    sel_q[1] = 1; a_q[1] = 16'h0003; b_q[1] = 16'h0004;
    build_expected(2);
    run_streams(2, 2, 2, 2, 0, 100, 8, "R3");

    // R2: heavy back-pressure, bursty producers
    for (int i = 0; i < 300; i++) begin
      sel_q[i] = ($urandom_range(99) < 80);
      a_q[i]   = DW'($urandom);
      b_q[i]   = DW'($urandom);
    end
    build_expected(300);
    run_streams(300, 300, 300, 300, 10, 25, 10, "R2");
    chk(out_valid == 0, "R3", "out_valid after final drain", out_valid, 0);
    chk(a_ready && b_ready && sel_ready, "R3", "all ready after final drain",
        {a_ready, b_ready, sel_ready}, 3'b111);

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule